// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps a wall-clock calendar: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A one-cycle tick advances it by one second, and the outcome is presented as seven byte-wide time registers. Each register is stored either as packed BCD or as plain binary. Hours can be shown in 24-hour form, or in 12-hour form with a PM flag. Month lengths and February in leap years are handled with the full Gregorian rule. The century used for that rule comes from a parameter.

Software programs the time through a byte write port. While the set-mode input is high, written bytes sit in the registers and are not overwritten by counting. When set mode is dropped, the counter takes its value from the registers. A write made outside set mode reloads the counter straight away. An oscillator-select field stops counting entirely unless it holds the run code. After each register refresh, a one-cycle strobe tells downstream flag logic that an update has finished.

Top module: `tod_calendar`

## Requirements
- R1: On an advance, seconds go 0..59 and wrap to 0 with a carry into minutes. Minutes likewise wrap at 60 into hours, and hours (0..23) wrap at 24 into a day rollover.
- R2: A day rollover steps the weekday through 1..7, and 7 is followed by 1.
- R3: Past the last day of the month the day returns to 1 and the month advances. Month lengths are Jan 31, Feb 28/29, Mar 31, Apr 30, May 31, Jun 30, Jul 31, Aug 31, Sep 30, Oct 31, Nov 30, Dec 31. Month 12 is followed by 1 with a year increment, and year 99 is followed by 00.
- R4: February has 29 days when the full year (BASE_YEAR plus the two-digit year, default BASE_YEAR 1900) is a multiple of 4 and is either not a multiple of 100 or is a multiple of 400. With the default, year 04 is a leap year and year 00 is not.
- R5: With binMode low, each register holds packed BCD (tens in bits 7:4, units in bits 3:0). With binMode high, each register holds the plain binary value. Written bytes are decoded in the same way.
- R6: With h24Mode low, the hour register holds the hour modulo 12, and bit 7 is set when the hour is 12 or more. When such a byte is loaded, bit 7 adds 12 to the decoded hour. With h24Mode high, the hour register holds 0..23 plainly.
- R7: A tick advances the time only when oscSel equals 3'b010. Ticks under any other oscSel value leave the registers unchanged and give no strobe.
- R8: A tick sampled at clock edge E changes the count at E. The registers show the new time after edge E+1, and updDone is high for exactly the one cycle after edge E+2.
- R9: While setMode is high, ticks neither refresh the registers nor raise updDone. Written bytes appear in their registers after the write edge.
- R10: At the first edge at which setMode is seen low after being high, the counter loads from the registers. A refresh due at that same edge is dropped, so the programmed values survive.
- R11: A write while setMode is low stores the byte and reloads the counter from the registers in the same edge, so counting continues from the written value. A tick in the same cycle as such a write is discarded.
- R12: wrSel selects the field: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year. A write with wrSel 7 changes no register.
- R13: After reset the registers read seconds 00, minutes 00, hours 00, weekday 01, day 01, month 01, year 00, and updDone is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle pulse per elapsed second |
| setMode | input | 1 | Holds registers against refresh while high; reload on its fall |
| binMode | input | 1 | 1 binary registers, 0 packed BCD |
| h24Mode | input | 1 | 1 for 24-hour hours, 0 for 12-hour with PM in bit 7 |
| oscSel | input | 3 | Oscillator control; counting only at 3'b010 |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Field selected for the write |
| wrData | input | 8 | Byte written |
| secOut | output | 8 | Seconds register |
| minOut | output | 8 | Minutes register |
| hourOut | output | 8 | Hours register |
| dowOut | output | 8 | Weekday register |
| domOut | output | 8 | Day-of-month register |
| monOut | output | 8 | Month register |
| yearOut | output | 8 | Two-digit year register |
| updDone | output | 1 | One-cycle strobe after each register refresh |

## Verification
The hardest case to reach is a tick taken while set mode is still high, followed by set mode falling exactly one cycle later. In that case the refresh pending from the tick meets the reload at the same edge. The bench produces this by holding the tick with set mode high for one edge, then lowering both together. After a counter that kept running during set mode has drifted away from freshly written register values, the bench checks that the written values survive and that no strobe follows. A write coinciding with a tick is provoked the same way, by driving both in a single cycle.

// File: rtl/tod_cal_pkg.sv
package tod_cal_pkg;

  localparam int FIELDS = 7;
  localparam int SEL_W  = $clog2(FIELDS);

  // Field order fixes the write selector encoding and the byte lanes.
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] dom;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } calTime_t;

  typedef struct packed {
    logic advance;    // step the binary count by one second
    logic refresh;    // copy the encoded count into the registers
    logic reloadCnt;  // load the count from the (merged) registers
    logic writeReg;   // store wrData into the selected register
  } calStrobe_t;

  localparam calTime_t RESET_TIME = {8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0};

  function automatic logic [7:0] binToBcd(input logic [7:0] v);
    logic [7:0] tens, ones;
    tens = (v % 8'd100) / 8'd10;
    ones = v % 8'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] bcdToBin(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] encodeVal(input logic [7:0] v, input logic bin);
    return bin ? v : binToBcd(v);
  endfunction

  function automatic logic [7:0] decodeVal(input logic [7:0] b, input logic bin);
    return bin ? b : bcdToBin(b);
  endfunction

  function automatic logic [7:0] encodeHour(input logic [7:0] h, input logic bin,
                                            input logic h24);
    logic [7:0] r;
    if (h24) r = encodeVal(h, bin);
    else     r = encodeVal(h % 8'd12, bin) | {(h >= 8'd12), 7'd0};
    return r;
  endfunction

  function automatic logic [7:0] decodeHour(input logic [7:0] b, input logic bin,
                                            input logic h24);
    logic [7:0] r;
    if (h24) r = decodeVal(b, bin);
    else     r = decodeVal({1'b0, b[6:0]}, bin) + (b[7] ? 8'd12 : 8'd0);
    return r;
  endfunction

  function automatic logic isLeapYear(input logic [15:0] y);
    return ((y % 16'd4) == 16'd0) &&
           (((y % 16'd100) != 16'd0) || ((y % 16'd400) == 16'd0));
  endfunction

  function automatic logic [7:0] monthDays(input logic [7:0] m, input logic leap);
    logic [7:0] d;
    case (m)
      8'd2:                   d = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: d = 8'd30;
      default:                d = 8'd31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tod_cal_ctrl.sv
module tod_cal_ctrl
  import tod_cal_pkg::*;
#(
  parameter logic [2:0] OSC_RUN = 3'b010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic [2:0] oscSel,
  input  logic       setMode,
  input  logic       wrEn,
  output calStrobe_t stb,
  output logic       updDone
);

  logic setPrev;
  logic pendQ;
  logic doneQ;
  logic oscOn;
  logic leaveSet;
  logic liveWr;

  always_comb begin
    oscOn         = (oscSel == OSC_RUN);
    leaveSet      = setPrev & ~setMode;
    liveWr        = wrEn & ~setMode;
    stb.writeReg  = wrEn;
    stb.reloadCnt = leaveSet | liveWr;
    // A reload wins over a tick and over a pending refresh.
    stb.advance   = secTick & oscOn & ~stb.reloadCnt;
    stb.refresh   = pendQ & ~setMode & ~stb.reloadCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setPrev <= 1'b0;
      pendQ   <= 1'b0;
      doneQ   <= 1'b0;
      updDone <= 1'b0;
    end else begin
      setPrev <= setMode;
      pendQ   <= stb.advance;
      doneQ   <= stb.refresh;
      updDone <= doneQ;
    end
  end

  // R9: a strobe needs a refresh two cycles back, impossible in set mode
  a_r9_no_done_in_set: assert property (@(posedge clk) disable iff (!rstN)
    $past(setMode, 2) |-> !updDone);

endmodule

// File: rtl/tod_cal_dp.sv
module tod_cal_dp
  import tod_cal_pkg::*;
#(
  parameter int BASE_YEAR = 1900
) (
  input  logic             clk,
  input  logic             rstN,
  input  calStrobe_t       stb,
  input  logic             binMode,
  input  logic             h24Mode,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [7:0]       wrData,
  output calTime_t         regTime
);

  localparam logic [15:0] YEAR_BASE = 16'(BASE_YEAR);

  calTime_t cnt;
  calTime_t nxt;
  calTime_t encTime;
  calTime_t mergedTime;
  calTime_t decTime;
  logic [FIELDS-1:0][7:0] regArr;
  logic [FIELDS-1:0][7:0] encArr;
  logic [FIELDS-1:0][7:0] mergedArr;
  logic [FIELDS-1:0][7:0] regNext;
  logic       leap;
  logic [7:0] mlen;

  assign regArr = regTime;
  assign encArr = encTime;

  // Per-lane register input: a write beats a refresh.
  for (genvar i = 0; i < FIELDS; i++) begin : g_lane
    logic hit;
    assign hit          = stb.writeReg && (wrSel == SEL_W'(i));
    assign mergedArr[i] = hit ? wrData : regArr[i];
    assign regNext[i]   = hit ? wrData : (stb.refresh ? encArr[i] : regArr[i]);
  end

  assign mergedTime = mergedArr;

  // Binary count one second ahead.
  always_comb begin
    nxt  = cnt;
    leap = isLeapYear(YEAR_BASE + {8'd0, cnt.year});
    mlen = monthDays(cnt.mon, leap);
    if (cnt.sec < 8'd59) begin
      nxt.sec = cnt.sec + 8'd1;
    end else begin
      nxt.sec = 8'd0;
      if (cnt.min < 8'd59) begin
        nxt.min = cnt.min + 8'd1;
      end else begin
        nxt.min = 8'd0;
        if (cnt.hour < 8'd23) begin
          nxt.hour = cnt.hour + 8'd1;
        end else begin
          nxt.hour = 8'd0;
          nxt.dow  = (cnt.dow >= 8'd7) ? 8'd1 : cnt.dow + 8'd1;
          if (cnt.dom < mlen) begin
            nxt.dom = cnt.dom + 8'd1;
          end else begin
            nxt.dom = 8'd1;
            if (cnt.mon < 8'd12) begin
              nxt.mon = cnt.mon + 8'd1;
            end else begin
              nxt.mon  = 8'd1;
              nxt.year = (cnt.year >= 8'd99) ? 8'd0 : cnt.year + 8'd1;
            end
          end
        end
      end
    end
  end

  // Count to register encoding.
  always_comb begin
    encTime.sec  = encodeVal(cnt.sec, binMode);
    encTime.min  = encodeVal(cnt.min, binMode);
    encTime.hour = encodeHour(cnt.hour, binMode, h24Mode);
    encTime.dow  = encodeVal(cnt.dow, binMode);
    encTime.dom  = encodeVal(cnt.dom, binMode);
    encTime.mon  = encodeVal(cnt.mon, binMode);
    encTime.year = encodeVal(cnt.year, binMode);
  end

  // Register to count decoding, including a write landing this cycle.
  always_comb begin
    decTime.sec  = decodeVal(mergedTime.sec, binMode);
    decTime.min  = decodeVal(mergedTime.min, binMode);
    decTime.hour = decodeHour(mergedTime.hour, binMode, h24Mode);
    decTime.dow  = decodeVal(mergedTime.dow, binMode);
    decTime.dom  = decodeVal(mergedTime.dom, binMode);
    decTime.mon  = decodeVal(mergedTime.mon, binMode);
    decTime.year = decodeVal(mergedTime.year, binMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= RESET_TIME;
      regTime <= RESET_TIME;
    end else begin
      regTime <= regNext;
      if (stb.reloadCnt)    cnt <= decTime;
      else if (stb.advance) cnt <= nxt;
    end
  end

  // R1: seconds never leave 0..59 after an advance
  a_r1_sec_wrap: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> (cnt.sec < 8'd60));

  // R2: a valid weekday stays in 1..7 across an advance
  a_r2_dow_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && cnt.dow >= 8'd1 && cnt.dow <= 8'd7) |=>
      (cnt.dow >= 8'd1 && cnt.dow <= 8'd7));

  // R11: the count moves only under an advance or a reload
  a_r11_count_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.advance || stb.reloadCnt) |=> $stable(cnt));

  // R9: registers change only under a write or a refresh
  a_r9_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.refresh || stb.writeReg) |=> $stable(regTime));

endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_cal_pkg::*;
#(
  parameter int         BASE_YEAR = 1900,
  parameter logic [2:0] OSC_RUN   = 3'b010
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secTick,
  input  logic             setMode,
  input  logic             binMode,
  input  logic             h24Mode,
  input  logic [2:0]       oscSel,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [7:0]       wrData,
  output logic [7:0]       secOut,
  output logic [7:0]       minOut,
  output logic [7:0]       hourOut,
  output logic [7:0]       dowOut,
  output logic [7:0]       domOut,
  output logic [7:0]       monOut,
  output logic [7:0]       yearOut,
  output logic             updDone
);

  calStrobe_t stb;
  calTime_t   regTime;

  tod_cal_ctrl #(.OSC_RUN(OSC_RUN)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .secTick (secTick),
    .oscSel  (oscSel),
    .setMode (setMode),
    .wrEn    (wrEn),
    .stb     (stb),
    .updDone (updDone)
  );

  tod_cal_dp #(.BASE_YEAR(BASE_YEAR)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .binMode (binMode),
    .h24Mode (h24Mode),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .regTime (regTime)
  );

  assign secOut  = regTime.sec;
  assign minOut  = regTime.min;
  assign hourOut = regTime.hour;
  assign dowOut  = regTime.dow;
  assign domOut  = regTime.dom;
  assign monOut  = regTime.mon;
  assign yearOut = regTime.year;

endmodule

// File: tb/tod_calendar_tb_top.sv
module tod_calendar_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       secTick, setMode, binMode, h24Mode, wrEn;
  logic [2:0] oscSel;
  logic [2:0] wrSel;
  logic [7:0] wrData;
  logic [7:0] secOut, minOut, hourOut, dowOut, domOut, monOut, yearOut;
  logic       updDone;

  int checks = 0;
  int errors = 0;
  int doneCount = 0;

  always #2 clk = ~clk;

  tod_calendar dut_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .setMode(setMode),
    .binMode(binMode), .h24Mode(h24Mode), .oscSel(oscSel), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .secOut(secOut), .minOut(minOut),
    .hourOut(hourOut), .dowOut(dowOut), .domOut(domOut), .monOut(monOut),
    .yearOut(yearOut), .updDone(updDone)
  );

  always @(negedge clk) if (updDone === 1'b1) doneCount++;

  // Layout: year, month, day, weekday, hour, minute, second
  typedef struct packed {
    logic        bin;
    logic        h24;
    logic [55:0] init;
    logic [55:0] expv;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 56'h00_01_01_01_00_00_00, 56'h00_01_01_01_00_00_01}, // R1
    '{1'b0, 1'b1, 56'h99_12_31_07_23_59_59, 56'h00_01_01_01_00_00_00}, // R2 R3
    '{1'b0, 1'b1, 56'h04_02_28_03_23_59_59, 56'h04_02_29_04_00_00_00}, // R4 leap
    '{1'b0, 1'b1, 56'h00_02_28_02_23_59_59, 56'h00_03_01_03_00_00_00}, // R4 1900
    '{1'b0, 1'b1, 56'h21_04_30_05_23_59_59, 56'h21_05_01_06_00_00_00}, // R3
    '{1'b1, 1'b1, 56'h63_0C_1F_06_17_3B_3B, 56'h00_01_01_07_00_00_00}, // R5
    '{1'b1, 1'b1, 56'h17_03_0A_02_0F_2A_1D, 56'h17_03_0A_02_0F_2A_1E}, // R5
    '{1'b0, 1'b0, 56'h10_06_15_03_11_59_59, 56'h10_06_15_03_80_00_00}, // R6
    '{1'b0, 1'b0, 56'h10_06_15_03_91_59_59, 56'h10_06_16_04_00_00_00}, // R6
    '{1'b1, 1'b0, 56'h14_07_04_05_85_3B_3B, 56'h14_07_04_05_86_00_00}, // R6
    '{1'b0, 1'b1, 56'h15_09_09_02_09_09_59, 56'h15_09_09_02_09_10_00}, // R5
    '{1'b0, 1'b1, 56'h23_01_31_01_23_59_59, 56'h23_02_01_02_00_00_00}  // R3
  };

  function automatic string vecReq(input int k);
    case (k)
      0:       return "R1";
      1:       return "R2 R3";
      2, 3:    return "R4";
      4, 11:   return "R3";
      5, 6, 10: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [55:0] regsNow();
    return {yearOut, monOut, domOut, dowOut, hourOut, minOut, secOut};
  endfunction

  task automatic checkVal(input string req, input string what,
                          input logic [55:0] act, input logic [55:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic writeField(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadTime(input logic bin, input logic h24, input logic [55:0] t);
    @(negedge clk);
    setMode = 1'b1; binMode = bin; h24Mode = h24;
    for (int i = 0; i < 7; i++) writeField(3'(i), t[i*8 +: 8]);
    setMode = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Returns just after the edge that samples the tick.
  task automatic tickOnce();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int snap;
    rstN = 1'b0; secTick = 1'b0; setMode = 1'b0; binMode = 1'b0;
    h24Mode = 1'b1; oscSel = 3'b010; wrEn = 1'b0; wrSel = 3'd0; wrData = 8'd0;
    repeat (3) @(negedge clk);
    checkVal("R13", "reset regs", regsNow(), 56'h00_01_01_01_00_00_00);
    checkVal("R13", "reset updDone", {55'd0, updDone}, 56'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: load, one tick, compare registers and strobe.
    for (int k = 0; k < NVEC; k++) begin
      loadTime(VECS[k].bin, VECS[k].h24, VECS[k].init);
      tickOnce();
      @(negedge clk);
      checkVal(vecReq(k), $sformatf("vector %0d regs", k), regsNow(), VECS[k].expv);
      @(negedge clk);
      checkVal("R8", $sformatf("vector %0d updDone", k), {55'd0, updDone}, 56'd1);
    end

    // R8 cycle placement
    loadTime(1'b0, 1'b1, 56'h20_03_10_02_08_30_15);
    tickOnce();
    checkVal("R8", "sec after tick edge", {48'd0, secOut}, 56'h15);
    checkVal("R8", "done after tick edge", {55'd0, updDone}, 56'd0);
    @(negedge clk);
    checkVal("R8", "sec after refresh edge", {48'd0, secOut}, 56'h16);
    checkVal("R8", "done with refresh", {55'd0, updDone}, 56'd0);
    @(negedge clk);
    checkVal("R8", "done one cycle later", {55'd0, updDone}, 56'd1);
    @(negedge clk);
    checkVal("R8", "done single cycle", {55'd0, updDone}, 56'd0);

    // R7 oscillator gate
    snap = doneCount;
    oscSel = 3'b000;
    tickOnce();
    repeat (3) @(negedge clk);
    oscSel = 3'b110;
    tickOnce();
    repeat (3) @(negedge clk);
    checkVal("R7", "stopped oscillator regs", regsNow(), 56'h20_03_10_02_08_30_16);
    checkVal("R7", "stopped oscillator strobes", 56'(doneCount - snap), 56'd0);
    oscSel = 3'b010;

    // R11 live write reloads the count
    writeField(3'd1, 8'h45);
    tickOnce();
    @(negedge clk);
    checkVal("R11", "live write then tick", regsNow(), 56'h20_03_10_02_08_45_17);

    // R11 write colliding with a tick drops the tick
    repeat (3) @(negedge clk);
    snap = doneCount;
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'd0; wrData = 8'h50; secTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; secTick = 1'b0;
    repeat (4) @(negedge clk);
    checkVal("R11", "collision sec", {48'd0, secOut}, 56'h50);
    checkVal("R11", "collision strobes", 56'(doneCount - snap), 56'd0);
    tickOnce();
    @(negedge clk);
    checkVal("R11", "count after collision", {48'd0, secOut}, 56'h51);

    // R12 selector 7 is ignored
    repeat (3) @(negedge clk);
    writeField(3'd7, 8'hAA);
    @(negedge clk);
    checkVal("R12", "selector 7 write", regsNow(), 56'h20_03_10_02_08_45_51);

    // R9 set mode freezes the registers
    snap = doneCount;
    @(negedge clk);
    setMode = 1'b1;
    tickOnce();
    tickOnce();
    repeat (3) @(negedge clk);
    checkVal("R9", "set mode regs", regsNow(), 56'h20_03_10_02_08_45_51);
    checkVal("R9", "set mode strobes", 56'(doneCount - snap), 56'd0);
    writeField(3'd0, 8'h05);
    checkVal("R9", "write in set mode", {48'd0, secOut}, 56'h05);

    // R10 tick in set mode, then set mode falls with the refresh pending
    snap = doneCount;
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0; setMode = 1'b0;
    repeat (3) @(negedge clk);
    checkVal("R10", "programmed regs kept", regsNow(), 56'h20_03_10_02_08_45_05);
    checkVal("R10", "no strobe on leave", 56'(doneCount - snap), 56'd0);
    tickOnce();
    @(negedge clk);
    checkVal("R10", "count from programmed regs", regsNow(), 56'h20_03_10_02_08_45_06);

    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule